// File: doc/BRIEF.md
# Multi-Line Receive Collector

This block gathers received characters from several serial lines into one shared queue. A single read port gives software access to the queue. Each line's deserialiser hands over a parallel character with a one-cycle strobe, along with framing-error and parity-error bits. The collector checks the per-line receive enable and tags each accepted character with the number of the line it came from. It then appends the character to the shared queue, so that one read word tells software both what arrived and where it came from.

Software drains the queue by pulsing a read request until the valid bit of the presented word is clear. There is no dedicated break indication: a break reaches software as a zero character carrying the framing-error bit. A queue-not-empty status combines with an interrupt enable to form the interrupt request. If the queue has no room, incoming characters are lost. The next character that is actually stored carries an overrun mark, so software can tell that data went missing just before it.

Top module: `line_rx_collector`

## Requirements
- R1: The read word is 16 bits wide. Bits [7:0] hold the character and bits [11:8] hold the source line number. Bit 12 is the parity error, bit 13 the framing error, bit 14 the overrun mark and bit 15 the valid flag.
- R2: While the queue is non-empty, `rd_word` presents the oldest entry. A cycle with `rd_req` high removes it, and the following entry is presented from the next cycle on.
- R3: While the queue is empty, `rd_word` reads as all zeros. A read request in that state changes nothing.
- R4: Each line has an enable bit, written by a cycle with `cfg_we` high that carries `cfg_line` and `cfg_rx_en`. Reset clears all enables. A strobe on a disabled line is discarded, and a write takes effect for strobes from the next cycle on.
- R5: When several enabled lines strobe in the same cycle, all of them are stored in that cycle if room allows, in ascending line order.
- R6: The queue holds 16 entries. Free room is counted from the occupancy at the start of the cycle, so a read in the same cycle does not make room. Strobes beyond the room are dropped, highest line numbers first.
- R7: After one or more characters are dropped, the first character stored afterwards carries the overrun mark. Entries stored after it do not.
- R8: The framing-error and parity-error inputs travel with their character unchanged. A zero character with the framing error set, which is how a break appears, is stored as such.
- R9: `rx_done` is high exactly while the queue holds at least one entry. It rises in the cycle after the first write.
- R10: `rx_irq` is high exactly when `rx_done` and `rx_irq_en` are both high.
- R11: After reset the queue is empty, and `rx_done`, `rx_irq` and `rd_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_stb | input | NUM_LINES | Per-line character strobe |
| rx_char | input | NUM_LINES*8 | Per-line character, line k at bits [8k+7:8k] |
| rx_ferr | input | NUM_LINES | Per-line framing error with the strobe |
| rx_perr | input | NUM_LINES | Per-line parity error with the strobe |
| cfg_we | input | 1 | Line-parameter write strobe |
| cfg_line | input | LINE_W | Line addressed by the write |
| cfg_rx_en | input | 1 | Receive enable value written |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_req | input | 1 | Pop the presented entry |
| rd_word | output | 16 | Presented entry (format in R1) |
| rx_done | output | 1 | Queue non-empty |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions take the strobe, error and configuration inputs as known, 0 or 1, in every cycle after reset. They also take every configured line number as naming an existing line. The stimulus respects both: every input is driven from a defined value at each falling edge, and with four lines the two-bit line field cannot address a line that does not exist. The random phases vary the read rate between filling and draining so that the full and overrun cases are reached, and they toggle the line enables and the interrupt enable only occasionally.

// File: rtl/rxq_pkg.sv
// Shared types for the multi-line receive collector.
// Assumes line numbers fit in four bits (at most 16 lines).
package rxq_pkg;
    localparam int CHAR_W   = 8;
    localparam int LFIELD_W = 4;
    localparam int WORD_W   = 16;

    typedef struct packed {
        logic                oerr;
        logic                ferr;
        logic                perr;
        logic [LFIELD_W-1:0] line;
        logic [CHAR_W-1:0]   chr;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_line_en.sv
// Per-line receive enable bank, written one line at a time.
// Assumes cfg_line addresses an existing line; reset disables all lines.
module rxq_line_en #(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [LINE_W-1:0]    cfg_line,
    input  logic                 cfg_en,
    output logic [NUM_LINES-1:0] en
);
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_en
        // Hold the enable of line k; update on a write that names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en[k] <= 1'b0;
            else if (cfg_we && cfg_line == LINE_W'(k))
                en[k] <= cfg_en;
        end
    end
endmodule

// File: rtl/rxq_merge.sv
// Orders same-cycle strobes by line number, grants queue slots up to the
// free room and builds tagged entries. Keeps the pending-overrun marker.
// Assumes NUM_LINES <= DEPTH and that strobes arrive already masked.
module rxq_merge
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        stb,
    input  logic [NUM_LINES*CHAR_W-1:0] chars,
    input  logic [NUM_LINES-1:0]        ferr,
    input  logic [NUM_LINES-1:0]        perr,
    input  logic [CNT_W-1:0]            occ,
    output logic [NUM_LINES-1:0]        we,
    output logic [CNT_W-1:0]            offs [NUM_LINES],
    output rxq_entry_t                  ent  [NUM_LINES],
    output logic [CNT_W-1:0]            nstore
);
    logic [CNT_W-1:0] free_slots;
    logic [CNT_W-1:0] rank [NUM_LINES];
    logic             drop;
    logic             ovr_pend;

    // Rank each strobing line among lower ones and grant while room remains.
    always_comb begin
        logic [CNT_W-1:0] run;
        free_slots = CNT_W'(DEPTH) - occ;
        run        = '0;
        drop       = 1'b0;
        nstore     = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            rank[k] = run;
            we[k]   = stb[k] && (run < free_slots);
            if (stb[k] && !we[k])
                drop = 1'b1;
            if (we[k])
                nstore = nstore + 1'b1;
            if (stb[k])
                run = run + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_ent
        // Build the tagged entry for line k; the overrun mark goes to rank 0.
        always_comb begin
            offs[k]     = rank[k];
            ent[k].oerr = ovr_pend && (rank[k] == '0);
            ent[k].ferr = ferr[k];
            ent[k].perr = perr[k];
            ent[k].line = LFIELD_W'(k);
            ent[k].chr  = chars[k*CHAR_W +: CHAR_W];
        end
    end

    // Remember a loss until the next stored entry has carried the mark.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_pend <= 1'b0;
        else if (drop)
            ovr_pend <= 1'b1;
        else if (|we)
            ovr_pend <= 1'b0;
    end
endmodule

// File: rtl/rxq_store.sv
// Circular entry store with several writes and one pop per cycle.
// Assumes DEPTH is a power of two and that the writer never grants more
// slots than DEPTH minus the occupancy at the start of the cycle.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] we,
    input  logic [CNT_W-1:0]     offs [NUM_LINES],
    input  rxq_entry_t           ent  [NUM_LINES],
    input  logic [CNT_W-1:0]     nstore,
    input  logic                 pop_req,
    output logic [CNT_W-1:0]     occ,
    output rxq_entry_t           head,
    output logic                 nonempty
);
    localparam int PW = $clog2(DEPTH);

    rxq_entry_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          pop;

    // A pop only takes effect when an entry is present.
    always_comb begin
        pop      = pop_req && (occ != '0);
        nonempty = (occ != '0);
        head     = mem[rd_ptr];
    end

    // Write every granted entry at its slot after the current tail.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_LINES; k++) begin
            if (we[k])
                mem[wr_ptr + PW'(offs[k])] <= ent[k];
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(nstore);
            rd_ptr <= rd_ptr + PW'(pop);
            occ    <= occ + nstore - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/line_rx_collector.sv
// Top of the multi-line receive collector: masks strobes with the line
// enables, merges them into the shared store and presents the oldest
// entry as a 16-bit read word with valid, error, line and character.
// Assumes 2 <= NUM_LINES <= 16, NUM_LINES <= DEPTH, DEPTH a power of two.
module line_rx_collector
    import rxq_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        rx_stb,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_char,
    input  logic [NUM_LINES-1:0]        rx_ferr,
    input  logic [NUM_LINES-1:0]        rx_perr,
    input  logic                        cfg_we,
    input  logic [LINE_W-1:0]           cfg_line,
    input  logic                        cfg_rx_en,
    input  logic                        rx_irq_en,
    input  logic                        rd_req,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        rx_done,
    output logic                        rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NUM_LINES-1:0] line_en;
    logic [NUM_LINES-1:0] stb_ok;
    logic [NUM_LINES-1:0] wr_en;
    logic [CNT_W-1:0]     wr_offs [NUM_LINES];
    rxq_entry_t           wr_ent  [NUM_LINES];
    logic [CNT_W-1:0]     wr_cnt;
    logic [CNT_W-1:0]     occ;
    rxq_entry_t           head;
    logic                 nonempty;

    rxq_line_en #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_line(cfg_line),
        .cfg_en  (cfg_rx_en),
        .en      (line_en)
    );

    // Discard strobes on lines that are not enabled.
    always_comb stb_ok = rx_stb & line_en;

    rxq_merge #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb_ok),
        .chars (rx_char),
        .ferr  (rx_ferr),
        .perr  (rx_perr),
        .occ   (occ),
        .we    (wr_en),
        .offs  (wr_offs),
        .ent   (wr_ent),
        .nstore(wr_cnt)
    );

    rxq_store #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .offs    (wr_offs),
        .ent     (wr_ent),
        .nstore  (wr_cnt),
        .pop_req (rd_req),
        .occ     (occ),
        .head    (head),
        .nonempty(nonempty)
    );

    // Present the head entry with its valid flag, or zeros when empty.
    always_comb begin
        rd_word = nonempty ? {1'b1, head} : '0;
        rx_done = nonempty;
        rx_irq  = nonempty && rx_irq_en;
    end
endmodule

// File: rtl/rxq_collector_chk.sv
// Property checker for the receive collector, attached by bind.
// Assumes inputs are known after reset.
module rxq_collector_chk #(
    parameter int NUM_LINES = 4,
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] rx_stb,
    input logic [NUM_LINES-1:0] line_en,
    input logic                 rd_req,
    input logic                 rx_irq_en,
    input logic                 rx_done,
    input logic                 rx_irq,
    input logic [15:0]          rd_word,
    input logic [CNT_W-1:0]     occ
);
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_irq_en && rx_done));

    a_r3_empty_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> (rd_word == 16'h0000));

    a_r3_empty_read_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_done && rx_stb == '0) |=> !rx_done);

    a_r2_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rx_done && rx_stb == '0) |=> (occ == $past(occ) - 1'b1));

    a_r4_disabled_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_stb & line_en) == '0 && !rd_req) |=> $stable(occ));

    a_r9_done_vs_occ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done == (occ != '0));
endmodule

bind line_rx_collector rxq_collector_chk #(
    .NUM_LINES(NUM_LINES), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_stb   (rx_stb),
    .line_en  (line_en),
    .rd_req   (rd_req),
    .rx_irq_en(rx_irq_en),
    .rx_done  (rx_done),
    .rx_irq   (rx_irq),
    .rd_word  (rd_word),
    .occ      (occ)
);

// File: tb/line_rx_collector_tb.sv
module line_rx_collector_tb;
    localparam int NL = 4;
    localparam int QD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] rx_stb = '0;
    logic [NL*8-1:0] rx_char = '0;
    logic [NL-1:0] rx_ferr = '0;
    logic [NL-1:0] rx_perr = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_line = '0;
    logic          cfg_rx_en = 1'b0;
    logic          rx_irq_en = 1'b0;
    logic          rd_req = 1'b0;
    logic [15:0]   rd_word;
    logic          rx_done;
    logic          rx_irq;

    int checks = 0;
    int errors = 0;

    logic [15:0] mq[$];
    bit          mpend = 1'b0;
    bit [NL-1:0] men = '0;

    line_rx_collector #(.NUM_LINES(NL), .DEPTH(QD)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_char(rx_char),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .cfg_we(cfg_we),
        .cfg_line(cfg_line), .cfg_rx_en(cfg_rx_en), .rx_irq_en(rx_irq_en),
        .rd_req(rd_req), .rd_word(rd_word), .rx_done(rx_done), .rx_irq(rx_irq)
    );

    always #2 clk = ~clk;

    // R1 word layout: valid 15, overrun 14, framing 13, parity 12, line 11:8, char 7:0
    function automatic logic [15:0] mk_word(bit o, bit f, bit p, int ln, logic [7:0] ch);
        return {1'b1, o, f, p, 4'(ln), ch};
    endfunction

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Check outputs against the model, apply one cycle, update the model.
    task automatic step(input logic [NL-1:0] s, input logic [NL*8-1:0] c,
                        input logic [NL-1:0] f, input logic [NL-1:0] p,
                        input logic rd, input logic cw, input logic [1:0] cl,
                        input logic ce, input string tag);
        logic [15:0] exp_w;
        bit          exp_d;
        int          free_n;
        int          rank;
        bit          dropped;
        bit          stored;
        rx_stb = s; rx_char = c; rx_ferr = f; rx_perr = p;
        rd_req = rd; cfg_we = cw; cfg_line = cl; cfg_rx_en = ce;
        #1;
        exp_d = (mq.size() != 0);
        exp_w = exp_d ? mq[0] : 16'h0000;
        chk(rd_word === exp_w, {tag, " word"}, rd_word, exp_w);
        chk(rx_done === exp_d, {tag, " R9 done"}, 16'(rx_done), 16'(exp_d));
        chk(rx_irq === (exp_d && rx_irq_en), {tag, " R10 irq"}, 16'(rx_irq),
            16'(exp_d && rx_irq_en));
        free_n = QD - mq.size();
        rank = 0; dropped = 0; stored = 0;
        for (int k = 0; k < NL; k++) begin
            if (s[k] && men[k]) begin
                if (rank < free_n) begin
                    mq.push_back(mk_word(mpend && rank == 0, f[k], p[k], k, c[k*8 +: 8]));
                    stored = 1;
                end else
                    dropped = 1;
                rank++;
            end
        end
        if (dropped) mpend = 1;
        else if (stored) mpend = 0;
        if (rd && free_n != QD) void'(mq.pop_front());
        if (cw) men[cl] = ce;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic rd, input string tag);
        step('0, '0, '0, '0, rd, 1'b0, 2'd0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rx_irq_en = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state, with interrupt enable high
        chk(rd_word === 16'h0, "R11 reset word", rd_word, 16'h0);
        chk(rx_done === 1'b0, "R11 reset done", 16'(rx_done), 16'h0);
        chk(rx_irq === 1'b0, "R11 reset irq", 16'(rx_irq), 16'h0);
        rst_n = 1'b1;

        // R4 all lines disabled after reset: strobes vanish
        step(4'hF, 32'h44332211, '0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R4 disabled");
        idle(1'b0, "R4 still empty");
        for (int k = 0; k < NL; k++)
            step('0, '0, '0, '0, 1'b0, 1'b1, 2'(k), 1'b1, "R4 enable");

        // R5 simultaneous strobes stored lowest line first; R1 field check
        step(4'hF, 32'hD4C3B2A1, 4'b0100, 4'b1000, 1'b0, 1'b0, 2'd0, 1'b0, "R5 all lines");
        chk(rd_word === mk_word(0, 0, 0, 0, 8'hA1), "R1 head format", rd_word,
            mk_word(0, 0, 0, 0, 8'hA1));
        for (int k = 0; k < NL; k++) idle(1'b1, "R2 R5 drain");

        // R8 break as zero char with framing error; parity on line 1
        step(4'b0110, 32'h005A_0000 | 32'h0000_3C00, 4'b0100, 4'b0010, 1'b0,
             1'b0, 2'd0, 1'b0, "R8 break parity");
        chk(rd_word === mk_word(0, 0, 1, 1, 8'h3C), "R8 parity entry", rd_word,
            mk_word(0, 0, 1, 1, 8'h3C));
        idle(1'b1, "R8 pop");
        chk(rd_word === mk_word(0, 1, 0, 2, 8'h5A), "R8 line2 entry", rd_word,
            mk_word(0, 1, 0, 2, 8'h5A));
        step(4'b0100, 32'h0, 4'b0100, 4'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R8 break entry");
        chk(rd_word === mk_word(0, 1, 0, 2, 8'h00), "R8 break stored", rd_word,
            mk_word(0, 1, 0, 2, 8'h00));
        idle(1'b1, "R8 drain");

        // R3 read on empty changes nothing
        idle(1'b1, "R3 empty read");
        idle(1'b0, "R3 after empty read");

        // R4 disable line 1, its strobe is dropped
        step('0, '0, '0, '0, 1'b0, 1'b1, 2'd1, 1'b0, "R4 disable");
        step(4'b0010, 32'h0000_7700, '0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R4 ignored");
        chk(rx_done === 1'b0, "R4 nothing stored", 16'(rx_done), 16'h0);
        step('0, '0, '0, '0, 1'b0, 1'b1, 2'd1, 1'b1, "R4 re-enable");

        // R6 R7 fill past capacity, read while full, then drain
        for (int i = 0; i < 5; i++)
            step(4'hF, {8'(i), 8'(i + 16), 8'(i + 32), 8'(i + 48)}, '0, '0,
                 1'b0, 1'b0, 2'd0, 1'b0, "R6 fill");
        step(4'b0001, 32'h0000_00EE, '0, '0, 1'b1, 1'b0, 2'd0, 1'b0, "R6 read at full");
        step(4'b0011, 32'h0000_CCBB, '0, '0, 1'b0, 1'b0, 2'd0, 1'b0, "R7 mark next");
        rx_irq_en = 1'b0;
        for (int i = 0; i < 18; i++) idle(1'b1, "R7 R10 drain");
        rx_irq_en = 1'b1;

        // Random mix, filling then draining phases
        for (int i = 0; i < 4000; i++) begin
            logic [NL-1:0] s;
            logic [NL*8-1:0] c;
            s = NL'($urandom);
            c = {$urandom} & (($urandom % 4 == 0) ? 32'h00FF00FF : 32'hFFFFFFFF);
            if (i % 200 == 0) rx_irq_en = ~rx_irq_en;
            step(s, c, NL'($urandom % 7 == 0 ? $urandom : 0),
                 NL'($urandom % 7 == 0 ? $urandom : 0),
                 ((i / 500) % 2 == 0) ? ($urandom % 5 == 0) : ($urandom % 5 != 0),
                 $urandom % 23 == 0, 2'($urandom), ($urandom % 4) != 0,
                 "R1/R2/R6/R7 random");
        end
        for (int i = 0; i < 20; i++) idle(1'b1, "R2 final drain");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule